// File: doc/BRIEF.md
# Clock Control Safe-Mode Override

This block is the control and status logic of a system clock controller. Software programs several settings through a small register bus: a bypass for each main-PLL output counter, the source of the flash-controller clock, a set of clock dividers and a set of clock enables. The block drives the effective values of these settings to the clock generation circuits. A sticky safe-mode bit sits on top of those settings. A cold reset sets it, and so does a one-cycle request from the reset controller. While the bit is set, the effective outputs take fixed safe values: every main counter is bypassed to the reference oscillator, the dividers take their reset defaults, the flash clock comes from the peripheral PLL, and every enable is on. The programmed registers keep their contents and can still be read back, so clearing the bit brings the programmed configuration back at once.

The block also watches the lock signal of three PLLs. Each lock signal is synchronized and edge-detected. A gain of lock and a loss of lock each set their own sticky status bit. The status bits are masked by an enable register and merged into one registered interrupt line.

Top module: `clkmgr_safe_ctl`

## Requirements
- R1: While `cold_rst` is high and after it falls, the control register (address 0) reads 0x1 (safe mode on, every other bit 0), the divider register (address 1) reads each divider at the default 4, the enable register (address 2) reads all ones, and the interrupt enable (address 3) and status (address 4) registers read 0. Unmapped addresses read 0.
- R2: A one-cycle `safe_req` sets control bit 0 and changes no other bit of any register.
- R3: The safe-mode bit stays set until a bus write to address 0 with data bit 0 equal to 0 clears it. A write with bit 0 equal to 1 sets it. When `safe_req` and a clearing write occur in the same cycle, the bit ends set.
- R4: While safe mode is on, `main_byp_o` is all ones. Otherwise it equals control bits [3:1].
- R5: While safe mode is on, `div_o` holds the default 4 in each 8-bit divider field. The divider register still reads back its programmed value, with divider i in bits [8i+7:8i].
- R6: While safe mode is on, `flash_sel_o` is 1 (1 selects the peripheral PLL). Otherwise it equals control bit 4.
- R7: While safe mode is on, `clk_en_o` is all ones. Otherwise it equals the enable register.
- R8: In the first cycle after a write clears the safe-mode bit, all effective outputs equal the programmed register values.
- R9: A rising edge of `pll_lock[p]` sets status bit 2p (lock gained), and a falling edge sets bit 2p+1 (lock lost). Each bit is set within three clock edges of the input change, after a two-flop synchronizer.
- R10: Status bits are sticky. A write to address 4 clears exactly those bits whose data bit is 1. Data bits that are 0 have no effect.
- R11: `irq_o` is a register loaded each cycle with the OR of (status AND interrupt enable). It is 0 when no enabled status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset |
| safe_req | input | 1 | Safe-mode request from the reset controller |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pll_lock | input | 3 | Asynchronous PLL lock signals |
| main_byp_o | output | 3 | Effective bypass of main counters C0..C2 |
| flash_sel_o | output | 1 | Effective flash clock source, 1 = peripheral PLL |
| div_o | output | 24 | Effective divider values, 8 bits each |
| clk_en_o | output | 8 | Effective clock enables |
| irq_o | output | 1 | Registered interrupt |

## Verification
The hardest case to show is that safe mode overrides the outputs and leaves the stored settings unchanged. From reset, the programmed and effective values are identical, so no override can be seen. The stimulus therefore first leaves safe mode and programs non-default bypass, divider and enable values. Only then does it raise the request. It then compares the forced outputs against the read-back registers, clears the bit, and expects the programmed values in the very next cycle. Interrupt sources are reached by toggling the lock inputs with the mask closed and then open. This separates status capture from the interrupt line.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_DIV     = 3'd1,
        REG_CLKEN   = 3'd2,
        REG_INTEN   = 3'd3,
        REG_INTSTAT = 3'd4
    } ckm_reg_e;

    typedef struct packed {
        logic gained;
        logic lost;
    } lock_evt_t;

    function automatic int gain_idx(input int p);
        return 2 * p;
    endfunction

    function automatic int loss_idx(input int p);
        return 2 * p + 1;
    endfunction

endpackage

// File: rtl/ckm_lock_edge.sv
module ckm_lock_edge
    import ckm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      cold_rst,
    input  logic      lock_async,
    output lock_evt_t evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], lock_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        evt.gained = sync_q[STAGES-1] & ~prev_q;
        evt.lost   = ~sync_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/ckm_regfile.sv
module ckm_regfile
    import ckm_pkg::*;
#(
    parameter int NUM_MCNT = 3,
    parameter int NUM_DIV  = 3,
    parameter int DIV_W    = 8,
    parameter int DIV_RST  = 4,
    parameter int NUM_EN   = 8,
    parameter int NUM_SRC  = 6
) (
    input  logic                     clk,
    input  logic                     cold_rst,
    input  logic                     safe_req,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_SRC-1:0]       evt_vec,
    output logic                     safe_q,
    output logic [NUM_MCNT-1:0]      byp_q,
    output logic                     flash_q,
    output logic [NUM_DIV*DIV_W-1:0] div_q,
    output logic [NUM_EN-1:0]        en_q,
    output logic [NUM_SRC-1:0]       ien_q,
    output logic [NUM_SRC-1:0]       stat_q
);
    localparam int DIVS     = NUM_DIV * DIV_W;
    localparam int FLASH_B  = NUM_MCNT + 1;

    logic wr_ctrl, wr_div, wr_en, wr_ien, wr_stat;
    logic [NUM_SRC-1:0] clr_mask;

    assign wr_ctrl  = bus_we && (bus_addr == REG_CTRL);
    assign wr_div   = bus_we && (bus_addr == REG_DIV);
    assign wr_en    = bus_we && (bus_addr == REG_CLKEN);
    assign wr_ien   = bus_we && (bus_addr == REG_INTEN);
    assign wr_stat  = bus_we && (bus_addr == REG_INTSTAT);
    assign clr_mask = wr_stat ? bus_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            safe_q  <= 1'b1;
            byp_q   <= '0;
            flash_q <= 1'b0;
            div_q   <= {NUM_DIV{DIV_W'(DIV_RST)}};
            en_q    <= '1;
            ien_q   <= '0;
            stat_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                safe_q  <= bus_wdata[0];
                byp_q   <= bus_wdata[NUM_MCNT:1];
                flash_q <= bus_wdata[FLASH_B];
            end
            if (safe_req) safe_q <= 1'b1;
            if (wr_div) div_q <= bus_wdata[DIVS-1:0];
            if (wr_en)  en_q  <= bus_wdata[NUM_EN-1:0];
            if (wr_ien) ien_q <= bus_wdata[NUM_SRC-1:0];
            stat_q <= (stat_q & ~clr_mask) | evt_vec;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[0]          = safe_q;
                bus_rdata[NUM_MCNT:1] = byp_q;
                bus_rdata[FLASH_B]    = flash_q;
            end
            REG_DIV:     bus_rdata[DIVS-1:0]    = div_q;
            REG_CLKEN:   bus_rdata[NUM_EN-1:0]  = en_q;
            REG_INTEN:   bus_rdata[NUM_SRC-1:0] = ien_q;
            REG_INTSTAT: bus_rdata[NUM_SRC-1:0] = stat_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ckm_safe_ovr.sv
module ckm_safe_ovr #(
    parameter int NUM_MCNT = 3,
    parameter int NUM_DIV  = 3,
    parameter int DIV_W    = 8,
    parameter int DIV_RST  = 4,
    parameter int NUM_EN   = 8
) (
    input  logic                     safe,
    input  logic [NUM_MCNT-1:0]      prog_byp,
    input  logic                     prog_flash,
    input  logic [NUM_DIV*DIV_W-1:0] prog_div,
    input  logic [NUM_EN-1:0]        prog_en,
    output logic [NUM_MCNT-1:0]      eff_byp,
    output logic                     eff_flash,
    output logic [NUM_DIV*DIV_W-1:0] eff_div,
    output logic [NUM_EN-1:0]        eff_en
);
    genvar d;
    generate
        for (d = 0; d < NUM_DIV; d++) begin : g_div
            assign eff_div[d*DIV_W +: DIV_W] =
                safe ? DIV_W'(DIV_RST) : prog_div[d*DIV_W +: DIV_W];
        end
    endgenerate

    assign eff_byp   = safe ? '1 : prog_byp;
    assign eff_flash = safe | prog_flash;
    assign eff_en    = safe ? '1 : prog_en;
endmodule

// File: rtl/clkmgr_safe_ctl.sv
module clkmgr_safe_ctl
    import ckm_pkg::*;
#(
    parameter int NUM_PLL  = 3,
    parameter int NUM_MCNT = 3,
    parameter int NUM_DIV  = 3,
    parameter int DIV_W    = 8,
    parameter int DIV_RST  = 4,
    parameter int NUM_EN   = 8,
    parameter int SYNC_N   = 2
) (
    input  logic                     clk,
    input  logic                     cold_rst,
    input  logic                     safe_req,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_PLL-1:0]       pll_lock,
    output logic [NUM_MCNT-1:0]      main_byp_o,
    output logic                     flash_sel_o,
    output logic [NUM_DIV*DIV_W-1:0] div_o,
    output logic [NUM_EN-1:0]        clk_en_o,
    output logic                     irq_o
);
    localparam int NUM_SRC = 2 * NUM_PLL;

    lock_evt_t [NUM_PLL-1:0]   pll_evt;
    logic [NUM_SRC-1:0]        evt_vec;
    logic                      safe_act;
    logic [NUM_MCNT-1:0]       prog_byp;
    logic                      prog_flash;
    logic [NUM_DIV*DIV_W-1:0]  prog_div;
    logic [NUM_EN-1:0]         prog_en;
    logic [NUM_SRC-1:0]        int_en;
    logic [NUM_SRC-1:0]        int_stat;

    genvar p;
    generate
        for (p = 0; p < NUM_PLL; p++) begin : g_pll
            ckm_lock_edge #(.STAGES(SYNC_N)) i_edge (
                .clk        (clk),
                .cold_rst   (cold_rst),
                .lock_async (pll_lock[p]),
                .evt        (pll_evt[p])
            );
            assign evt_vec[gain_idx(p)] = pll_evt[p].gained;
            assign evt_vec[loss_idx(p)] = pll_evt[p].lost;
        end
    endgenerate

    ckm_regfile #(
        .NUM_MCNT(NUM_MCNT), .NUM_DIV(NUM_DIV), .DIV_W(DIV_W),
        .DIV_RST(DIV_RST), .NUM_EN(NUM_EN), .NUM_SRC(NUM_SRC)
    ) i_regs (
        .clk       (clk),
        .cold_rst  (cold_rst),
        .safe_req  (safe_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_vec   (evt_vec),
        .safe_q    (safe_act),
        .byp_q     (prog_byp),
        .flash_q   (prog_flash),
        .div_q     (prog_div),
        .en_q      (prog_en),
        .ien_q     (int_en),
        .stat_q    (int_stat)
    );

    ckm_safe_ovr #(
        .NUM_MCNT(NUM_MCNT), .NUM_DIV(NUM_DIV), .DIV_W(DIV_W),
        .DIV_RST(DIV_RST), .NUM_EN(NUM_EN)
    ) i_ovr (
        .safe       (safe_act),
        .prog_byp   (prog_byp),
        .prog_flash (prog_flash),
        .prog_div   (prog_div),
        .prog_en    (prog_en),
        .eff_byp    (main_byp_o),
        .eff_flash  (flash_sel_o),
        .eff_div    (div_o),
        .eff_en     (clk_en_o)
    );

    always_ff @(posedge clk) begin
        if (cold_rst) irq_o <= 1'b0;
        else          irq_o <= |(int_stat & int_en);
    end
endmodule

// File: rtl/ckm_safe_chk.sv
module ckm_safe_chk
    import ckm_pkg::*;
#(
    parameter int NUM_MCNT = 3,
    parameter int NUM_DIV  = 3,
    parameter int DIV_W    = 8,
    parameter int DIV_RST  = 4,
    parameter int NUM_EN   = 8,
    parameter int NUM_SRC  = 6
) (
    input logic                     clk,
    input logic                     cold_rst,
    input logic                     safe_req,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic                     safe_act,
    input logic [NUM_SRC-1:0]       int_stat,
    input logic [NUM_SRC-1:0]       int_en,
    input logic [NUM_MCNT-1:0]      main_byp_o,
    input logic                     flash_sel_o,
    input logic [NUM_DIV*DIV_W-1:0] div_o,
    input logic [NUM_EN-1:0]        clk_en_o,
    input logic                     irq_o
);
    a_r2_req_sets: assert property (@(posedge clk) disable iff (cold_rst)
        safe_req |=> safe_act);

    a_r3_sticky: assert property (@(posedge clk) disable iff (cold_rst)
        safe_act && !(bus_we && bus_addr == REG_CTRL && !bus_wdata[0]) |=> safe_act);

    a_r4_bypass: assert property (@(posedge clk) disable iff (cold_rst)
        safe_act |-> (&main_byp_o));

    a_r5_div_default: assert property (@(posedge clk) disable iff (cold_rst)
        safe_act |-> (div_o == {NUM_DIV{DIV_W'(DIV_RST)}}));

    a_r6_flash_periph: assert property (@(posedge clk) disable iff (cold_rst)
        safe_act |-> flash_sel_o);

    a_r7_all_enabled: assert property (@(posedge clk) disable iff (cold_rst)
        safe_act |-> (&clk_en_o));

    a_r10_stat_sticky: assert property (@(posedge clk) disable iff (cold_rst)
        !(bus_we && bus_addr == REG_INTSTAT) |=> ((int_stat & $past(int_stat)) == $past(int_stat)));

    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (cold_rst)
        (int_en == '0) |=> !irq_o);
endmodule

bind clkmgr_safe_ctl ckm_safe_chk #(
    .NUM_MCNT(NUM_MCNT), .NUM_DIV(NUM_DIV), .DIV_W(DIV_W),
    .DIV_RST(DIV_RST), .NUM_EN(NUM_EN), .NUM_SRC(2 * NUM_PLL)
) i_chk (
    .clk         (clk),
    .cold_rst    (cold_rst),
    .safe_req    (safe_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .safe_act    (safe_act),
    .int_stat    (int_stat),
    .int_en      (int_en),
    .main_byp_o  (main_byp_o),
    .flash_sel_o (flash_sel_o),
    .div_o       (div_o),
    .clk_en_o    (clk_en_o),
    .irq_o       (irq_o)
);

// File: tb/test_clkmgr_safe_ctl.sv
module test_clkmgr_safe_ctl;
    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        safe_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [2:0]  pll_lock = 3'b000;
    logic [2:0]  main_byp_o;
    logic        flash_sel_o;
    logic [23:0] div_o;
    logic [7:0]  clk_en_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    clkmgr_safe_ctl i_clkmgr_safe_ctl (
        .clk(clk), .cold_rst(cold_rst), .safe_req(safe_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pll_lock(pll_lock),
        .main_byp_o(main_byp_o), .flash_sel_o(flash_sel_o),
        .div_o(div_o), .clk_en_o(clk_en_o), .irq_o(irq_o)
    );

    localparam int S_RD = 0, S_BYP = 1, S_FL = 2, S_DIV = 3, S_EN = 4, S_IRQ = 5;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            S_RD:    return bus_rdata;
            S_BYP:   return {29'd0, main_byp_o};
            S_FL:    return {31'd0, flash_sel_o};
            S_DIV:   return {8'd0, div_o};
            S_EN:    return {24'd0, clk_en_o};
            default: return {31'd0, irq_o};
        endcase
    endfunction

    // monitor: pops expectations pushed at a falling edge, compares 1 ns later
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(string tag, int sel, logic [31:0] e);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = e;
        sb_q.push_back(it);
    endtask

    task automatic expect_reg(string tag, int a, logic [31:0] e);
        @(negedge clk);
        bus_addr = 3'(a);
        expect_out(tag, S_RD, e);
    endtask

    task automatic wr(int a, logic [31:0] d, bit with_req);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d; safe_req = with_req;
        @(negedge clk);
        bus_we = 1'b0; safe_req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset values
        expect_reg("R1 ctrl", 0, 32'h1);
        cold_rst = 1'b0;
        expect_reg("R1 div", 1, 32'h040404);
        expect_reg("R1 clken", 2, 32'hFF);
        expect_reg("R1 inten", 3, 32'h0);
        expect_reg("R1 stat", 4, 32'h0);
        expect_reg("R1 unmapped", 7, 32'h0);
        expect_out("R1 irq", S_IRQ, 0);
        expect_out("R4 byp at reset", S_BYP, 32'h7);

        // R8: leave safe mode, program non-default values
        wr(0, 32'h04, 0);
        expect_out("R8 byp", S_BYP, 32'h2);
        expect_out("R8 flash", S_FL, 0);
        wr(1, 32'h030201, 0);
        expect_out("R8 div", S_DIV, 32'h030201);
        wr(2, 32'h0F, 0);
        expect_out("R8 clken", S_EN, 32'h0F);

        // R2/R4-R7: one-cycle request
        @(negedge clk); safe_req = 1'b1;
        @(negedge clk); safe_req = 1'b0;
        expect_out("R4 byp forced", S_BYP, 32'h7);
        expect_out("R5 div forced", S_DIV, 32'h040404);
        expect_out("R6 flash forced", S_FL, 1);
        expect_out("R7 en forced", S_EN, 32'hFF);
        expect_reg("R2 ctrl", 0, 32'h05);
        expect_reg("R5 div readback", 1, 32'h030201);
        expect_reg("R2 clken kept", 2, 32'h0F);
        idle(6);
        expect_reg("R3 sticky", 0, 32'h05);

        // R3: request wins over simultaneous clear
        wr(0, 32'h04, 1);
        expect_reg("R3 req wins", 0, 32'h05);

        // R8: clear returns programmed values next cycle
        wr(0, 32'h04, 0);
        expect_out("R8 byp back", S_BYP, 32'h2);
        expect_out("R8 div back", S_DIV, 32'h030201);
        expect_out("R8 en back", S_EN, 32'h0F);
        expect_out("R8 flash back", S_FL, 0);
        wr(0, 32'h10, 0);
        expect_out("R6 flash programmed", S_FL, 1);
        expect_out("R4 byp programmed", S_BYP, 0);
        wr(0, 32'h01, 0);
        expect_reg("R3 sw set", 0, 32'h01);
        wr(0, 32'h00, 0);
        expect_reg("R3 sw clear", 0, 32'h00);

        // R9/R11: lock gain on PLL1 with mask closed
        @(negedge clk); pll_lock[1] = 1'b1;
        idle(5);
        expect_reg("R9 gain pll1", 4, 32'h04);
        expect_out("R11 masked", S_IRQ, 0);
        wr(3, 32'h04, 0);
        idle(1);
        expect_out("R11 irq on", S_IRQ, 1);
        // R10: zero write no effect, one write clears
        wr(4, 32'h00, 0);
        expect_reg("R10 zero write", 4, 32'h04);
        wr(4, 32'h04, 0);
        expect_reg("R10 w1c", 4, 32'h00);
        idle(1);
        expect_out("R11 irq off", S_IRQ, 0);
        // R9: loss on PLL1, gains on PLL0 and PLL2
        @(negedge clk); pll_lock[1] = 1'b0; pll_lock[0] = 1'b1; pll_lock[2] = 1'b1;
        idle(5);
        expect_reg("R9 mixed", 4, 32'h19);
        expect_out("R11 loss masked", S_IRQ, 0);

        idle(3);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule